// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether a single memory access may proceed, given a table of protection entries. Each entry supplies an inclusive byte range (lowest and highest address), an enable field, read/write/execute permission bits and a lock bit. A request carries a byte address, a byte count, the set of requested permissions and the privilege mode of the requester. The block compares both the first and the last byte of the access with every entry. The lowest-numbered entry that holds either byte decides the outcome.

The result is registered: one clock after a request is presented, the block reports whether the access is granted. It also reports whether an entry decided it and, if so, which one. An access that straddles the edge of its deciding entry is refused in every mode. Machine mode ignores the permission bits of an unlocked entry and is allowed through when nothing matches. Lower privilege modes are held to the permission bits and are refused when nothing matches. A table with no enabled entry lets every access through.

Top module: `pmp_access_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, `resp_valid`, `resp_grant` and `resp_hit` are 0 after that edge.
- R2: Every request sampled with `req_valid` high gives `resp_valid` high on the following clock. A clock with `req_valid` low gives `resp_valid`, `resp_grant` and `resp_hit` low on the following clock, and `resp_idx` is 0 whenever `resp_hit` is 0.
- R3: When no entry is enabled, every access is granted with `resp_hit` = 0, in every privilege mode and for every permission set.
- R4: The last byte is `req_addr + size - 1` (modulo 2^AW). Each of the first and last bytes lies inside an entry when lo <= byte <= hi, with both bounds inclusive.
- R5: Entries are scanned from index 0 upward. The lowest-index enabled entry holding either byte decides the result, and `resp_idx` reports that index with `resp_hit` = 1.
- R6: If the deciding entry holds exactly one of the two bytes, the access is denied, in machine mode too, with `resp_hit` = 1.
- R7: Machine mode (`req_priv` = 3) with a full match on an unlocked entry is granted for any requested set.
- R8: In every other full match, the allowed set is the entry's cfg bits [0] read, [1] write and [2] execute, and cfg bit [5] marks a locked entry. The access is granted only when every requested bit (`req_perm` bit 0 read, bit 1 write, bit 2 execute) lies in the allowed set. An empty request is always granted.
- R9: When at least one entry is enabled and none holds either byte, the access is granted for machine mode and denied for supervisor (`req_priv` = 1) and user (`req_priv` = 0), with `resp_hit` = 0.
- R10: A `req_size` of 0 means WORD_BYTES bytes when `paging_en` is 0. When `paging_en` is 1 it means the bytes from `req_addr` up to the end of its 2^PAGE_BITS-byte page.
- R11: An entry whose cfg field [4:3] is 0 is disabled and never matches, whatever its range and bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this clock |
| req_addr | input | AW | Byte address of the first byte |
| req_size | input | AW | Access length in bytes, 0 = default length |
| req_perm | input | 3 | Requested set: bit 0 read, bit 1 write, bit 2 execute |
| req_priv | input | 2 | Privilege: 3 machine, 1 supervisor, 0 user |
| paging_en | input | 1 | Address translation active (selects the default length) |
| ent_lo | input | N*AW | Per-entry lowest byte address, entry i at [i*AW +: AW] |
| ent_hi | input | N*AW | Per-entry highest byte address, entry i at [i*AW +: AW] |
| ent_cfg | input | N*6 | Per-entry config: [2:0] XWR, [4:3] enable, [5] lock |
| resp_valid | output | 1 | Result present |
| resp_grant | output | 1 | Access allowed |
| resp_hit | output | 1 | An entry decided the result |
| resp_idx | output | IW | Index of the deciding entry |

## Verification
A fault in the priority pick, or in a range comparison on either byte, shows on `resp_idx` or `resp_grant` exactly one clock after the request. The stimulus therefore places accesses where two entries overlap, on the inclusive bounds, and across an entry edge in both directions. A wrong default length only shows when the stretched access crosses an entry edge, so the size-zero cases are placed next to entry ends, both with and without paging. Lock and mode handling is exercised by sending the same address from machine and user mode against locked and unlocked entries, so a wrong permission mask turns one grant into a refusal or the reverse.

// File: rtl/pmp_chk_pkg.sv
// Shared definitions for the protection checker: config field positions
// and privilege encodings. Assumes a 6-bit per-entry configuration.
package pmp_chk_pkg;
    localparam int CFG_BITS   = 6;
    localparam int CFG_RD     = 0;
    localparam int CFG_WR     = 1;
    localparam int CFG_EX     = 2;
    localparam int CFG_EN_LO  = 3;
    localparam int CFG_EN_HI  = 4;
    localparam int CFG_LOCK   = 5;

    typedef logic [2:0] perm_t;

    typedef enum logic [1:0] {
        PRIV_USR  = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_MACH = 2'd3
    } priv_e;
endpackage

// File: rtl/pmp_chk_size.sv
// Computes the address of the last byte of an access. A zero length is
// replaced by a word length, or by the rest of the page when paging is on.
// Assumes PAGE_BITS < AW. Wrap-around is modulo 2^AW.
module pmp_chk_size #(
    parameter int AW         = 32,
    parameter int PAGE_BITS  = 12,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] size,
    input  logic          paging,
    output logic [AW-1:0] last
);
    localparam logic [AW-1:0] PAGE_LEN = AW'(1) << PAGE_BITS;
    localparam logic [AW-1:0] WORD_LEN = AW'(WORD_BYTES);

    logic [AW-1:0] page_off;
    logic [AW-1:0] eff_len;

    // Pick the effective length and form the last byte address.
    always_comb begin
        page_off = {{(AW-PAGE_BITS){1'b0}}, addr[PAGE_BITS-1:0]};
        if (size != '0)
            eff_len = size;
        else if (paging)
            eff_len = PAGE_LEN - page_off;
        else
            eff_len = WORD_LEN;
        last = addr + eff_len - AW'(1);
    end
endmodule

// File: rtl/pmp_chk_range.sv
// Inclusive range test of the first and last byte against one entry.
// A disabled entry reports neither byte inside.
module pmp_chk_range #(
    parameter int AW = 32
) (
    input  logic          en,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] last,
    output logic          first_in,
    output logic          last_in
);
    // Compare both ends of the access with the bounds.
    always_comb begin
        first_in = en && (first >= lo) && (first <= hi);
        last_in  = en && (last  >= lo) && (last  <= hi);
    end
endmodule

// File: rtl/pmp_chk_prio.sv
// Fixed-priority selector: reports the lowest set bit of the request
// vector. The index is 0 when nothing is set.
module pmp_chk_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan downward so the lowest index is written last and wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pmp_access_checker.sv
// Access permission checker. Scans N protection entries in fixed priority
// order and registers a grant/hit/index result one clock after a request.
// Assumes the entry table is stable while a request is sampled.
module pmp_access_checker
    import pmp_chk_pkg::*;
#(
    parameter int N          = 8,
    parameter int AW         = 32,
    parameter int PAGE_BITS  = 12,
    parameter int WORD_BYTES = 4,
    localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [AW-1:0]         req_addr,
    input  logic [AW-1:0]         req_size,
    input  logic [2:0]            req_perm,
    input  logic [1:0]            req_priv,
    input  logic                  paging_en,
    input  logic [N*AW-1:0]       ent_lo,
    input  logic [N*AW-1:0]       ent_hi,
    input  logic [N*CFG_BITS-1:0] ent_cfg,
    output logic                  resp_valid,
    output logic                  resp_grant,
    output logic                  resp_hit,
    output logic [IW-1:0]         resp_idx
);
    logic [AW-1:0] last_byte;
    logic [N-1:0]  en_v;
    logic [N-1:0]  any_in;
    logic [N-1:0]  part_v;
    logic [N-1:0]  lock_v;
    perm_t         perm_arr [N];

    logic          found;
    logic [IW-1:0] pick;
    logic          any_active;
    perm_t         allowed;
    logic          grant_d;

    pmp_chk_size #(
        .AW(AW), .PAGE_BITS(PAGE_BITS), .WORD_BYTES(WORD_BYTES)
    ) u_size (
        .addr(req_addr), .size(req_size), .paging(paging_en), .last(last_byte)
    );

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [CFG_BITS-1:0] cfg;
        logic                fin;
        logic                lin;

        assign cfg         = ent_cfg[g*CFG_BITS +: CFG_BITS];
        assign en_v[g]     = |cfg[CFG_EN_HI:CFG_EN_LO];
        assign lock_v[g]   = cfg[CFG_LOCK];
        assign perm_arr[g] = {cfg[CFG_EX], cfg[CFG_WR], cfg[CFG_RD]};

        pmp_chk_range #(.AW(AW)) u_rng (
            .en(en_v[g]),
            .lo(ent_lo[g*AW +: AW]),
            .hi(ent_hi[g*AW +: AW]),
            .first(req_addr),
            .last(last_byte),
            .first_in(fin),
            .last_in(lin)
        );

        assign any_in[g] = fin | lin;
        assign part_v[g] = fin ^ lin;
    end

    pmp_chk_prio #(.N(N), .IW(IW)) u_prio (
        .cand(any_in), .found(found), .idx(pick)
    );

    assign any_active = |en_v;

    // Form the allowed set and the grant decision for the current request.
    always_comb begin
        if ((req_priv == PRIV_MACH) && !lock_v[pick])
            allowed = 3'b111;
        else
            allowed = perm_arr[pick];

        if (!any_active)
            grant_d = 1'b1;
        else if (found)
            grant_d = !part_v[pick] && ((req_perm & ~allowed) == 3'b000);
        else
            grant_d = (req_priv == PRIV_MACH);
    end

    // Register the result; idle clocks clear grant, hit and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
            resp_hit   <= 1'b0;
            resp_idx   <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_grant <= req_valid && grant_d;
            resp_hit   <= req_valid && any_active && found;
            resp_idx   <= (req_valid && any_active && found) ? pick : '0;
        end
    end
endmodule

// File: rtl/pmp_access_checker_sva.sv
// Property checker for the access checker, attached through bind.
module pmp_access_checker_sva
    import pmp_chk_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [1:0]            req_priv,
    input logic [N*CFG_BITS-1:0] ent_cfg,
    input logic                  resp_valid,
    input logic                  resp_grant,
    input logic                  resp_hit,
    input logic [IW-1:0]         resp_idx
);
    logic tbl_active;

    // Independent view of whether the table has any enabled entry.
    always_comb begin
        tbl_active = 1'b0;
        for (int i = 0; i < N; i++)
            tbl_active |= |ent_cfg[i*CFG_BITS+CFG_EN_LO +: 2];
    end

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_grant && !resp_hit)); // R2
    AST_EMPTY_TABLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tbl_active) |=> (resp_grant && !resp_hit)); // R3
    AST_LOW_PRIV_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tbl_active && (req_priv != PRIV_MACH)) |=> (resp_hit || !resp_grant)); // R9
    AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (int'(resp_idx) < N)); // R5
    AST_IDX_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_hit |-> (resp_idx == '0)); // R2
endmodule

bind pmp_access_checker pmp_access_checker_sva #(.N(N), .IW(IW)) u_sva (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_priv(req_priv),
    .ent_cfg(ent_cfg),
    .resp_valid(resp_valid),
    .resp_grant(resp_grant),
    .resp_hit(resp_hit),
    .resp_idx(resp_idx)
);

// File: tb/pmp_access_checker_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results from a requirement
// model, the monitor compares them with each registered response.
module pmp_access_checker_bench;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int PB = 12;
    localparam int WB = 4;
    localparam int IW = 3;
    localparam int CB = 6;

    typedef struct {
        logic  grant;
        logic  hit;
        int    idx;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [AW-1:0]     req_size = '0;
    logic [2:0]        req_perm = '0;
    logic [1:0]        req_priv = '0;
    logic              paging_en = 1'b0;
    logic [N*AW-1:0]   ent_lo;
    logic [N*AW-1:0]   ent_hi;
    logic [N*CB-1:0]   ent_cfg;
    logic              resp_valid;
    logic              resp_grant;
    logic              resp_hit;
    logic [IW-1:0]     resp_idx;

    logic [AW-1:0] t_lo  [N];
    logic [AW-1:0] t_hi  [N];
    logic [CB-1:0] t_cfg [N];

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    pmp_access_checker #(.N(N), .AW(AW), .PAGE_BITS(PB), .WORD_BYTES(WB)) u_pmp_access_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_perm(req_perm), .req_priv(req_priv),
        .paging_en(paging_en), .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg),
        .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_hit(resp_hit),
        .resp_idx(resp_idx)
    );

    // Pack the bench table onto the flat entry ports.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_lo[i*AW +: AW]  = t_lo[i];
            ent_hi[i*AW +: AW]  = t_hi[i];
            ent_cfg[i*CB +: CB] = t_cfg[i];
        end
    end

    // Requirement model of one access.
    function automatic exp_t model(logic [AW-1:0] a, logic [AW-1:0] s,
                                   logic [2:0] p, logic [1:0] pv, logic pg);
        exp_t r;
        logic [AW-1:0] len, lst;
        logic fi, li, act;
        logic [2:0] alw;
        r.grant = 1'b0; r.hit = 1'b0; r.idx = 0; r.tag = "";
        if (s != 0) len = s;
        else if (pg) len = (AW'(1) << PB) - AW'(a % (1 << PB));
        else len = AW'(WB);
        lst = a + len - 1;
        act = 1'b0;
        for (int i = 0; i < N; i++) if (t_cfg[i][4:3] != 2'b00) act = 1'b1;
        if (!act) begin r.grant = 1'b1; return r; end
        for (int i = 0; i < N; i++) begin
            if (t_cfg[i][4:3] == 2'b00) continue;
            fi = (a >= t_lo[i]) && (a <= t_hi[i]);
            li = (lst >= t_lo[i]) && (lst <= t_hi[i]);
            if (fi || li) begin
                r.hit = 1'b1; r.idx = i;
                if (fi != li) begin r.grant = 1'b0; return r; end
                alw = (pv == 2'd3 && !t_cfg[i][5]) ? 3'b111 : t_cfg[i][2:0];
                r.grant = ((p & alw) == p);
                return r;
            end
        end
        r.grant = (pv == 2'd3);
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one request and queue its expected result.
    task automatic send(logic [AW-1:0] a, logic [AW-1:0] s, logic [2:0] p,
                        logic [1:0] pv, logic pg, string tag);
        exp_t e;
        @(negedge clk);
        req_addr = a; req_size = s; req_perm = p; req_priv = pv; paging_en = pg;
        req_valid = 1'b1;
        e = model(a, s, p, pv, pg);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Idle clock followed by a check that the output went quiet (R2).
    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R2", 32'(resp_valid), 32'd0, "idle resp_valid");
        check("R2", 32'(resp_hit), 32'd0, "idle resp_hit");
    endtask

    // Monitor: compare each response with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (q.size() == 0) begin
                check("R2", 32'd1, 32'd0, "response without request");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, 32'(resp_grant), 32'(e.grant), "grant");
                check(e.tag, 32'(resp_hit), 32'(e.hit), "hit");
                check(e.tag, 32'(resp_idx), e.hit ? 32'(e.idx) : 32'd0, "idx");
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin t_lo[i] = '0; t_hi[i] = '0; t_cfg[i] = '0; end
        rst_n = 1'b0;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 32'(resp_valid), 32'd0, "reset resp_valid");
        check("R1", 32'(resp_grant), 32'd0, "reset resp_grant");
        check("R1", 32'(resp_hit), 32'd0, "reset resp_hit");
        req_valid = 1'b0;
        rst_n = 1'b1;

        // Empty table: everything granted (R3).
        send(32'h0000_5000, 4, 3'b010, 2'd0, 1'b0, "R3");
        send(32'h0000_1000, 4, 3'b111, 2'd1, 1'b0, "R3");
        idle_check();

        // Table: e0 read-only, e1 locked RW overlapping e0, e2 exec,
        // e3 disabled covering everything, e4 RWX.
        t_lo[0] = 32'h1000; t_hi[0] = 32'h1FFF; t_cfg[0] = 6'b0_01_001;
        t_lo[1] = 32'h1800; t_hi[1] = 32'h27FF; t_cfg[1] = 6'b1_01_011;
        t_lo[2] = 32'h3000; t_hi[2] = 32'h30FF; t_cfg[2] = 6'b0_11_100;
        t_lo[3] = 32'h0;    t_hi[3] = 32'hFFFF_FFFF; t_cfg[3] = 6'b0_00_111;
        t_lo[4] = 32'h4000; t_hi[4] = 32'h4FFF; t_cfg[4] = 6'b0_10_111;

        send(32'h1000, 4, 3'b001, 2'd0, 1'b0, "R8");   // read in e0
        send(32'h1800, 4, 3'b010, 2'd0, 1'b0, "R5");   // e0 wins over e1, deny
        send(32'h1800, 4, 3'b010, 2'd3, 1'b0, "R7");   // machine, unlocked e0
        send(32'h1FFE, 4, 3'b001, 2'd0, 1'b0, "R6");   // straddles e0 end
        send(32'h1FFE, 4, 3'b001, 2'd3, 1'b0, "R6");   // machine still denied
        send(32'h0FFE, 4, 3'b001, 2'd3, 1'b0, "R4");   // only last byte inside
        send(32'h1FFC, 4, 3'b001, 2'd0, 1'b0, "R4");   // ends on inclusive bound
        send(32'h2000, 4, 3'b100, 2'd3, 1'b0, "R8");   // locked e1, no exec
        send(32'h2000, 4, 3'b011, 2'd1, 1'b0, "R8");   // RW on e1
        send(32'h1004, 4, 3'b000, 2'd0, 1'b0, "R8");   // empty request
        send(32'h5000, 4, 3'b001, 2'd0, 1'b0, "R11");  // only e3 covers, disabled
        send(32'h5000, 4, 3'b001, 2'd1, 1'b0, "R9");
        send(32'h5000, 4, 3'b111, 2'd3, 1'b0, "R9");
        send(32'h1FFC, 0, 3'b001, 2'd0, 1'b0, "R10");  // word length fits
        send(32'h1FFD, 0, 3'b001, 2'd0, 1'b0, "R10");  // word length straddles
        send(32'h4F00, 0, 3'b011, 2'd0, 1'b1, "R10");  // to page end inside e4
        send(32'h3080, 0, 3'b100, 2'd0, 1'b1, "R10");  // page tail leaves e2
        send(32'h3080, 0, 3'b100, 2'd0, 1'b0, "R10");  // word inside e2
        idle_check();
        repeat (3) @(negedge clk);
        check("R2", 32'(q.size()), 32'd0, "pending responses");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule